// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is one node of a two-dimensional mesh network. It has five links: a local link to the attached endpoint, and one link each toward north, south, east and west. Packets arrive as a sequence of flits. The first flit carries the destination coordinates. The following flits carry only data and go wherever the first one went. Every link moves one flit per cycle under a valid/ready handshake, so a stalled receiver pushes back through the router to the sender.

Each input holds only two flits. The router reads the destination in the leading flit and picks an output. It resolves X before Y. When several packets want the same output, a round-robin arbiter chooses one. The chosen input then owns that output until its last flit has passed. The leading flit goes out in the cycle after it is accepted. A packet that cannot advance stays spread across the routers behind it and is never collected in one place.

The router's own coordinates are parameters. Flit bits [DATA_W+1:DATA_W] hold the kind. In a leading flit, bits [X_W-1:0] hold the destination X and the next Y_W bits hold the destination Y. Port index 0 is local, 1 north (+Y), 2 south (−Y), 3 east (+X) and 4 west (−X). Flit i of a link occupies bits [i*FLIT_W +: FLIT_W] of that bus.

Top module: `meshRouter`

## Requirements
- R1: A leading flit (kind 01 or 11) whose destination X is larger than the router's X leaves on east (index 3). If the destination X is smaller, it leaves on west (index 4). The Y field is not considered in either case.
- R2: When the destination X equals the router's X, a larger destination Y selects north (index 1) and a smaller one selects south (index 2).
- R3: When both coordinates equal the router's own, the packet leaves on the local port (index 0).
- R4: A leading flit accepted on an input at a clock edge is presented, with its contents unchanged, on its chosen output before the next edge.
- R5: Once a leading flit is granted an output, that output carries only flits of that input until a flit of kind 10 or 11 leaves. A competing packet waits until then.
- R6: Each output arbitrates among waiting leading flits in round-robin order. After a packet's final flit leaves, the search for the next winner starts at the input index following that packet's input, wrapping from 4 to 0.
- R7: While an output has valid high and ready low, its flit stays unchanged. Each input stores at most two flits and drops its ready when both are occupied.
- R8: A flit of kind 11 is a complete packet. The output it leaves on is released in the same cycle, so a waiting packet from another input may follow directly.
- R9: Body (00) and tail (10) flits follow their packet's output, whatever values sit in their coordinate bit positions.
- R10: After reset, all outputs show valid low and all inputs show ready high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 5 | Per-input flit valid |
| inReady | output | 5 | Per-input ready (buffer not full) |
| inFlit | input | 5*FLIT_W | Incoming flits, one slice per input |
| outValid | output | 5 | Per-output flit valid |
| outReady | input | 5 | Per-output downstream ready |
| outFlit | output | 5*FLIT_W | Outgoing flits, one slice per output |

## Verification
Two functions can land in the same cycle: a final flit releases an output, and the arbiter picks the next owner of that output. Another contender is already waiting at that moment. The bench sets this up by holding an output's ready low while two inputs load packets toward it in the same cycle, then releasing ready. The scoreboard predicts the exact order of flits on that output from the round-robin pointer, which the bench tracks by hand, and any interleaving or wrong winner shows up as a mismatch. The same check is run against a packet that is already in flight, where a one-flit packet arrives on another input and must wait for the tail.

// File: rtl/meshRouterPkg.sv
package meshRouterPkg;
  localparam int NPORTS = 5;
  localparam int PORT_W = 3;

  localparam logic [PORT_W-1:0] P_LOCAL = 3'd0;
  localparam logic [PORT_W-1:0] P_NORTH = 3'd1;
  localparam logic [PORT_W-1:0] P_SOUTH = 3'd2;
  localparam logic [PORT_W-1:0] P_EAST  = 3'd3;
  localparam logic [PORT_W-1:0] P_WEST  = 3'd4;

  // bit0 marks a packet start, bit1 marks a packet end
  typedef enum logic [1:0] {
    FLIT_BODY = 2'b00,
    FLIT_HEAD = 2'b01,
    FLIT_TAIL = 2'b10,
    FLIT_SOLO = 2'b11
  } flitKind_e;

  // strobes from control to the buffer/crossbar datapath
  typedef struct packed {
    logic [NPORTS-1:0]        popMask;
    logic [NPORTS-1:0]        outEn;
    logic [NPORTS*PORT_W-1:0] outSel;
  } xbarStrobes_t;
endpackage

// File: rtl/meshFlitFifo.sv
module meshFlitFifo #(
  parameter int W     = 18,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pushValid,
  output logic         pushReady,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic         notEmpty,
  output logic [W-1:0] headData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush;

  assign pushReady = (count != CNT_W'(DEPTH));
  assign notEmpty  = (count != '0);
  assign doPush    = pushValid && pushReady;
  assign headData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + PTR_W'(1);
      if (pop)    rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + PTR_W'(1);
      case ({doPush, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R7: control never drains an empty buffer, occupancy stays bounded
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> notEmpty);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/meshRrPick.sv
module meshRrPick #(
  parameter int N     = 5,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] startIdx,
  output logic [IDX_W-1:0] pick,
  output logic             found
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(startIdx) + k) % N]) begin
        found = 1'b1;
        pick  = IDX_W'((int'(startIdx) + k) % N);
      end
    end
  end
endmodule

// File: rtl/meshRouterDatapath.sv
module meshRouterDatapath
  import meshRouterPkg::*;
#(
  parameter int FLIT_W = 18,
  parameter int DEPTH  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NPORTS-1:0]        inValid,
  output logic [NPORTS-1:0]        inReady,
  input  logic [NPORTS*FLIT_W-1:0] inFlit,
  input  xbarStrobes_t             strobes,
  output logic [NPORTS-1:0]        fifoNotEmpty,
  output logic [NPORTS*FLIT_W-1:0] fifoHead,
  output logic [NPORTS-1:0]        outValid,
  output logic [NPORTS*FLIT_W-1:0] outFlit
);
  for (genvar g = 0; g < NPORTS; g++) begin : g_inBuf
    meshFlitFifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rstN      (rstN),
      .pushValid (inValid[g]),
      .pushReady (inReady[g]),
      .pushData  (inFlit[g*FLIT_W +: FLIT_W]),
      .pop       (strobes.popMask[g]),
      .notEmpty  (fifoNotEmpty[g]),
      .headData  (fifoHead[g*FLIT_W +: FLIT_W])
    );
  end

  // crossbar: each output picks the head of the input that owns it
  always_comb begin
    for (int o = 0; o < NPORTS; o++) begin
      outFlit[o*FLIT_W +: FLIT_W] =
        fifoHead[int'(strobes.outSel[o*PORT_W +: PORT_W])*FLIT_W +: FLIT_W];
    end
  end

  assign outValid = strobes.outEn;
endmodule

// File: rtl/meshRouterCtrl.sv
module meshRouterCtrl
  import meshRouterPkg::*;
#(
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int DATA_W = 16,
  parameter int MY_X   = 2,
  parameter int MY_Y   = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NPORTS-1:0]            fifoNotEmpty,
  input  logic [NPORTS*(DATA_W+2)-1:0] fifoHead,
  input  logic [NPORTS-1:0]            outReady,
  output xbarStrobes_t                 strobes
);
  localparam int FLIT_W = DATA_W + 2;

  logic [1:0]        kind     [NPORTS];
  logic [PORT_W-1:0] route    [NPORTS];
  logic [NPORTS-1:0] isStart;
  logic [NPORTS-1:0] inLocked;
  logic [NPORTS-1:0] reqVec   [NPORTS];
  logic [NPORTS-1:0] ownedBy  [NPORTS];
  logic [PORT_W-1:0] grantIdx [NPORTS];
  logic [NPORTS-1:0] grantAny;
  logic [PORT_W-1:0] ownerEff [NPORTS];
  logic [NPORTS-1:0] outEn, fire, lastOut;
  logic [NPORTS-1:0] popMask;

  logic [NPORTS-1:0] outBusy;
  logic [PORT_W-1:0] outOwner [NPORTS];
  logic [PORT_W-1:0] rrPtr    [NPORTS];

  logic unusedHeadBits;
  assign unusedHeadBits = ^fifoHead;

  function automatic logic [PORT_W-1:0] dorRoute(input logic [X_W-1:0] dx,
                                                 input logic [Y_W-1:0] dy);
    if      (dx > X_W'(MY_X)) return P_EAST;
    else if (dx < X_W'(MY_X)) return P_WEST;
    else if (dy > Y_W'(MY_Y)) return P_NORTH;
    else if (dy < Y_W'(MY_Y)) return P_SOUTH;
    else                      return P_LOCAL;
  endfunction

  function automatic logic [PORT_W-1:0] nextPtr(input logic [PORT_W-1:0] p);
    return (p == PORT_W'(NPORTS-1)) ? '0 : p + PORT_W'(1);
  endfunction

  // decode head of each input buffer
  always_comb begin
    for (int i = 0; i < NPORTS; i++) begin
      kind[i]    = fifoHead[i*FLIT_W + DATA_W +: 2];
      isStart[i] = kind[i][0];
      route[i]   = dorRoute(fifoHead[i*FLIT_W +: X_W], fifoHead[i*FLIT_W + X_W +: Y_W]);
    end
  end

  // an input is locked while some output is reserved for it
  always_comb begin
    inLocked = '0;
    for (int o = 0; o < NPORTS; o++)
      for (int i = 0; i < NPORTS; i++)
        if (outBusy[o] && outOwner[o] == PORT_W'(i)) inLocked[i] = 1'b1;
  end

  always_comb begin
    for (int o = 0; o < NPORTS; o++)
      for (int i = 0; i < NPORTS; i++)
        reqVec[o][i] = fifoNotEmpty[i] && isStart[i] && !inLocked[i] &&
                       (route[i] == PORT_W'(o));
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_arb
    meshRrPick #(.N(NPORTS), .IDX_W(PORT_W)) u_pick (
      .req      (reqVec[g]),
      .startIdx (rrPtr[g]),
      .pick     (grantIdx[g]),
      .found    (grantAny[g])
    );
  end

  always_comb begin
    popMask = '0;
    for (int o = 0; o < NPORTS; o++) begin
      ownerEff[o] = outBusy[o] ? outOwner[o] : grantIdx[o];
      outEn[o]    = (outBusy[o] || grantAny[o]) && fifoNotEmpty[ownerEff[o]];
      fire[o]     = outEn[o] && outReady[o];
      lastOut[o]  = kind[ownerEff[o]][1];
      for (int i = 0; i < NPORTS; i++) begin
        ownedBy[i][o] = outEn[o] && (ownerEff[o] == PORT_W'(i));
        if (fire[o] && ownerEff[o] == PORT_W'(i)) popMask[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBusy <= '0;
      for (int o = 0; o < NPORTS; o++) begin
        outOwner[o] <= '0;
        rrPtr[o]    <= '0;
      end
    end else begin
      for (int o = 0; o < NPORTS; o++) begin
        if (!outBusy[o] && grantAny[o]) begin
          if (fire[o] && lastOut[o]) begin
            rrPtr[o] <= nextPtr(grantIdx[o]);
          end else begin
            outBusy[o]  <= 1'b1;
            outOwner[o] <= grantIdx[o];
          end
        end else if (outBusy[o] && fire[o] && lastOut[o]) begin
          outBusy[o] <= 1'b0;
          rrPtr[o]   <= nextPtr(outOwner[o]);
        end
      end
    end
  end

  always_comb begin
    strobes.popMask = popMask;
    strobes.outEn   = outEn;
    for (int o = 0; o < NPORTS; o++)
      strobes.outSel[o*PORT_W +: PORT_W] = ownerEff[o];
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_chk
    // R5: a flit that does not end its packet keeps the output reserved
    p_lock_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
      fire[g] && !lastOut[g] |=> outBusy[g]);
    // R8: a one-flit packet leaves the output free for the next cycle
    p_solo_free_r8: assert property (@(posedge clk) disable iff (!rstN)
      fire[g] && kind[ownerEff[g]] == 2'(FLIT_SOLO) |=> !outBusy[g]);
    // R5: no input is driven onto two outputs at once
    p_one_owner_r5: assert property (@(posedge clk) disable iff (!rstN)
      $countones(ownedBy[g]) <= 1);
  end
endmodule

// File: rtl/meshRouter.sv
module meshRouter
  import meshRouterPkg::*;
#(
  parameter int X_W        = 3,
  parameter int Y_W        = 3,
  parameter int DATA_W     = 16,
  parameter int MY_X       = 2,
  parameter int MY_Y       = 2,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [4:0]                   inValid,
  output logic [4:0]                   inReady,
  input  logic [5*(DATA_W+2)-1:0]      inFlit,
  output logic [4:0]                   outValid,
  input  logic [4:0]                   outReady,
  output logic [5*(DATA_W+2)-1:0]      outFlit
);
  localparam int FLIT_W = DATA_W + 2;

  xbarStrobes_t            strobes;
  logic [NPORTS-1:0]        fifoNotEmpty;
  logic [NPORTS*FLIT_W-1:0] fifoHead;

  meshRouterCtrl #(
    .X_W(X_W), .Y_W(Y_W), .DATA_W(DATA_W), .MY_X(MY_X), .MY_Y(MY_Y)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fifoNotEmpty (fifoNotEmpty),
    .fifoHead     (fifoHead),
    .outReady     (outReady),
    .strobes      (strobes)
  );

  meshRouterDatapath #(.FLIT_W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inReady      (inReady),
    .inFlit       (inFlit),
    .strobes      (strobes),
    .fifoNotEmpty (fifoNotEmpty),
    .fifoHead     (fifoHead),
    .outValid     (outValid),
    .outFlit      (outFlit)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_hold
    // R7: a stalled output keeps presenting the same flit
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
      outValid[g] && !outReady[g] |=>
        outValid[g] && $stable(outFlit[g*FLIT_W +: FLIT_W]));
  end
endmodule

// File: tb/test_meshRouter.sv
module test_meshRouter;
  localparam int FW = 18;
  localparam int NP = 5;
  localparam logic [1:0] KB = 2'b00, KH = 2'b01, KT = 2'b10, KS = 2'b11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rstN;
  logic [NP-1:0]    inValid, inReady, outValid, outReady;
  logic [FW-1:0]    inF [NP];
  logic [NP*FW-1:0] inFlit, outFlit;

  always_comb
    for (int p = 0; p < NP; p++) inFlit[p*FW +: FW] = inF[p];

  meshRouter i_meshRouter (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inFlit(inFlit),
    .outValid(outValid), .outReady(outReady), .outFlit(outFlit)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [FW-1:0] expQ [NP][$];
  string         tagQ [NP][$];
  logic [FW-1:0] expFront;
  string         tagFront;

  function automatic logic [FW-1:0] mk(logic [1:0] k, int x, int y, int tag);
    return {k, 10'(tag), 3'(y), 3'(x)};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectOut(int p, logic [FW-1:0] f, string tag);
    expQ[p].push_back(f);
    tagQ[p].push_back(tag);
  endtask

  // scoreboard monitor: compares every transfer against the queue of its output
  always begin
    @(negedge clk);
    #2;
    if (rstN) begin
      for (int p = 0; p < NP; p++) begin
        if (outValid[p] && outReady[p]) begin
          if (expQ[p].size() == 0) begin
            chk(1'b0, $sformatf("R5 unexpected flit on output %0d", p),
                int'(outFlit[p*FW +: FW]), 0);
          end else begin
            expFront = expQ[p].pop_front();
            tagFront = tagQ[p].pop_front();
            chk(outFlit[p*FW +: FW] == expFront, tagFront,
                int'(outFlit[p*FW +: FW]), int'(expFront));
          end
        end
      end
    end
  end

  task automatic sendFlit(int p, logic [FW-1:0] f);
    inF[p] = f;
    inValid[p] = 1'b1;
    #1;
    while (!inReady[p]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    inValid[p] = 1'b0;
  endtask

  function automatic int pending();
    int n = 0;
    for (int p = 0; p < NP; p++) n += expQ[p].size();
    return n;
  endfunction

  task automatic drain(string tag);
    int n = 0;
    while (pending() != 0 && n < 500) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    #3;
    chk(pending() == 0, tag, pending(), 0);
  endtask

  // R6: two packets compete for the local output, loaded in the same cycle
  task automatic contend(int a, int b, int first, int base, string tag);
    logic [FW-1:0] ha, ta, hb, tb;
    ha = mk(KH, 2, 2, base);     ta = mk(KT, 7, 7, base + 1);
    hb = mk(KH, 2, 2, base + 2); tb = mk(KT, 0, 0, base + 3);
    outReady[0] = 1'b0;
    if (first == a) begin
      expectOut(0, ha, tag); expectOut(0, ta, tag);
      expectOut(0, hb, tag); expectOut(0, tb, tag);
    end else begin
      expectOut(0, hb, tag); expectOut(0, tb, tag);
      expectOut(0, ha, tag); expectOut(0, ta, tag);
    end
    fork
      sendFlit(a, ha);
      sendFlit(b, hb);
    join
    fork
      sendFlit(a, ta);
      sendFlit(b, tb);
    join
    outReady[0] = 1'b1;
    drain(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] f, h, b, t;
    rstN = 1'b0;
    inValid = '0;
    outReady = '0;
    for (int p = 0; p < NP; p++) inF[p] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(outValid == 5'b00000, "R10 outValid after reset", int'(outValid), 0);
    chk(inReady == 5'b11111, "R10 inReady after reset", int'(inReady), 31);
    @(negedge clk);
    rstN = 1'b1;

    // R1/R2/R3: routing of single-flit packets from the local input
    outReady = 5'b11111;
    f = mk(KS, 5, 0, 1); expectOut(3, f, "R1 larger X goes east");  sendFlit(0, f);
    f = mk(KS, 0, 7, 2); expectOut(4, f, "R1 smaller X goes west"); sendFlit(0, f);
    f = mk(KS, 2, 6, 3); expectOut(1, f, "R2 larger Y goes north"); sendFlit(0, f);
    f = mk(KS, 2, 1, 4); expectOut(2, f, "R2 smaller Y goes south"); sendFlit(0, f);
    f = mk(KS, 2, 2, 5); expectOut(0, f, "R3 own address goes local"); sendFlit(0, f);
    drain("R3 routing drained");

    // R8: two single-flit packets to east, pointer at 1 after the first east solo
    outReady[3] = 1'b0;
    h = mk(KS, 6, 1, 30); t = mk(KS, 4, 4, 31);
    expectOut(3, h, "R8 solo from input 1 first");
    expectOut(3, t, "R8 solo from input 4 follows");
    fork
      sendFlit(1, h);
      sendFlit(4, t);
    join
    outReady[3] = 1'b1;
    drain("R8 solos drained");

    // R9: body and tail carry misleading coordinate bits
    h = mk(KH, 4, 2, 6); b = mk(KB, 0, 2, 7); t = mk(KT, 2, 2, 8);
    expectOut(3, h, "R9 head east");
    expectOut(3, b, "R9 body follows head");
    expectOut(3, t, "R9 tail follows head");
    sendFlit(2, h); sendFlit(2, b); sendFlit(2, t);
    drain("R9 packet drained");

    // R4/R7: cut-through visibility and back-pressure on east
    outReady[3] = 1'b0;
    h = mk(KH, 7, 3, 9); b = mk(KB, 1, 1, 10); t = mk(KT, 3, 3, 11);
    expectOut(3, h, "R7 head after stall");
    expectOut(3, b, "R7 body after stall");
    expectOut(3, t, "R7 tail after stall");
    sendFlit(0, h);
    #1;
    chk(outValid[3] == 1'b1, "R4 head valid one edge after accept", int'(outValid[3]), 1);
    chk(outFlit[3*FW +: FW] == h, "R4 head presented", int'(outFlit[3*FW +: FW]), int'(h));
    sendFlit(0, b);
    #1;
    chk(inReady[0] == 1'b0, "R7 ready low with two flits held", int'(inReady[0]), 0);
    repeat (3) @(negedge clk);
    #1;
    chk(outValid[3] == 1'b1, "R7 valid held while stalled", int'(outValid[3]), 1);
    chk(outFlit[3*FW +: FW] == h, "R7 flit stable while stalled", int'(outFlit[3*FW +: FW]), int'(h));
    outReady[3] = 1'b1;
    sendFlit(0, t);
    drain("R7 stalled packet drained");

    // R5: a solo packet must wait for an in-flight packet's tail
    h = mk(KH, 2, 2, 20); f = mk(KS, 2, 2, 21);
    b = mk(KB, 5, 5, 22); t = mk(KT, 0, 0, 23);
    expectOut(0, h, "R5 head of owner");
    expectOut(0, b, "R5 body of owner");
    expectOut(0, t, "R5 tail of owner");
    expectOut(0, f, "R5 waiting solo after tail");
    sendFlit(1, h);
    sendFlit(3, f);
    #1;
    chk(outValid[0] == 1'b0, "R5 locked output idles without owner data", int'(outValid[0]), 0);
    sendFlit(1, b);
    sendFlit(1, t);
    drain("R5 locked packet drained");

    // R6: local pointer is at 4 here; predicted winners follow the rotation
    contend(1, 3, 1, 40, "R6 round one input 1 first");
    contend(2, 4, 4, 50, "R6 round two input 4 first");
    contend(2, 3, 3, 60, "R6 round three input 3 first");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule